// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block forms the 32-bit unsigned product of two 16-bit operands using a single 16-bit adder that is reused for 16 consecutive cycles. It does not use an array multiplier. The multiplier operand is loaded into a right-shifting register, and its lowest bit decides each cycle whether the multiplicand or zero goes into the adder. The adder's other input is the upper part of a 17-bit accumulator. The sum and carry return to that accumulator, so the running partial product moves one place to the right on every step. Each bit that drops off the bottom of the accumulator enters a separate 15-bit shift register, which builds the low end of the result.

Operands arrive on a valid/ready handshake. `in_ready` is high only while the block is idle. A transfer happens on a rising edge where `in_valid` and `in_ready` are both high. While a multiplication runs, `in_ready` is low, so the source is held off. A pending `in_valid` then has no effect. The result side has no back-pressure. `done` pulses for exactly one cycle, and `product` keeps its value until the next operand transfer. A user that needs the result must capture it no later than that transfer.

Top module: `seq_mult`

## Requirements
- R1: While `rst_n` is low and on release: `done` = 0, `in_ready` = 1 and `product` = 0. Reset is asynchronous and acts at once.
- R2: `in_ready` is 1 only when the block is idle. A transfer (`in_valid` and `in_ready` high at a rising edge) loads both operands, clears the accumulator and drops `in_ready` in the next cycle.
- R3: Count the transfer edge as edge 1. `done` is high for exactly one cycle, in the cycle after edge 17, and at no other time.
- R4: When `done` is high, `product` equals `op_a * op_b` as unsigned numbers, using the operands captured at the transfer.
- R5: `in_valid` and operand changes during a multiplication are ignored. `in_ready` stays 0, and the result is that of the operands accepted at the transfer.
- R6: From the `done` cycle until the next transfer, `product` does not change.
- R7: A 0 bit in the multiplier adds zero but still shifts the accumulator. Zero operands give 0, and 0xFFFF × 0xFFFF gives 0xFFFE0001.
- R8: Asserting `rst_n` low during a multiplication abandons it. `done` stays 0 and `in_ready` returns to 1 without waiting for a clock edge.
- R9: In the cycle after `done`, `in_ready` is 1, so a source that keeps `in_valid` high starts the next multiplication one cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block is idle and will take an operand pair |
| op_a | input | 16 | Multiplicand |
| op_b | input | 16 | Multiplier |
| done | output | 1 | One-cycle flag: product is valid |
| product | output | 32 | Unsigned product, held until the next transfer |

## Verification
The bench targets the operand extremes: zero in either position, all-ones squared, a single high bit and a single low bit. A mishandled carry-out or a wrong bit retired into the low register corrupts exactly these values. It holds `in_valid` high with different operands all through a multiplication. A design that sampled operands after the transfer, or raised ready early, would then return a mixed result. It measures the distance from transfer to `done` on every operation and keeps `in_valid` high across back-to-back transfers. An off-by-one step counter or a lost ready cycle shows up as a wrong latency or a gap. It also pulls reset in mid-operation and watches for a stale `done` or a stuck `in_ready`.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } smul_state_e;
endpackage

// File: rtl/smul_ctrl.sv
// Sequencer: idle -> STEPS accumulate cycles -> one done cycle -> idle.
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int STEPS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic load,
  output logic step,
  output logic done
);
  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  smul_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  assign in_ready = (state_q == ST_IDLE);
  assign load     = in_ready && in_valid;
  assign step     = (state_q == ST_RUN);
  assign done     = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (in_valid) state_d = ST_RUN;
      ST_RUN:  if (cnt_q == LAST) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load)      cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: done never lasts more than one cycle
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: idle again right after done
  p_done_then_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> in_ready);
  // R2: a transfer closes the handshake for the following cycle
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !done));
  // R5: an unfinished run cannot be left early, whatever in_valid does
  p_run_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q != LAST) |=> (step && !in_ready));
endmodule

// File: rtl/smul_shreg.sv
// Right-shifting register with parallel load; serial bit enters at the top.
module smul_shreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (load_en)  q <= load_val;
    else if (shift_en) q <= {ser_in, q[W-1:1]};
  end
endmodule

// File: rtl/smul_accum.sv
// Partial-product register: upper W bits plus gated addend, carry kept on top.
module smul_accum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         add_sel,
  input  logic [W-1:0] addend,
  output logic [W:0]   acc
);
  logic [W-1:0] gated;
  logic [W:0]   sum;

  assign gated = add_sel ? addend : '0;
  assign sum   = {1'b0, acc[W:1]} + {1'b0, gated};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= '0;
    else if (en)  acc <= sum;
  end

  // R7: with a 0 multiplier bit the accumulator only shifts right
  p_zero_bit_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && !add_sel) |=> (acc == {1'b0, $past(acc[W:1])}));
endmodule

// File: rtl/seq_mult.sv
module seq_mult #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int LOW_W = W - 1;

  logic         load, step;
  logic [W-1:0] mcand_q;
  logic [W-1:0] mplier;
  logic [W:0]   acc;
  logic [LOW_W-1:0] low;

  smul_ctrl #(.STEPS(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .load(load), .step(step), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mcand_q <= '0;
    else if (load) mcand_q <= op_a;
  end

  smul_shreg #(.W(W)) u_mplier (
    .clk(clk), .rst_n(rst_n), .load_en(load), .load_val(op_b),
    .shift_en(step), .ser_in(1'b0), .q(mplier)
  );

  smul_accum #(.W(W)) u_accum (
    .clk(clk), .rst_n(rst_n), .clr(load), .en(step),
    .add_sel(mplier[0]), .addend(mcand_q), .acc(acc)
  );

  smul_shreg #(.W(LOW_W)) u_low (
    .clk(clk), .rst_n(rst_n), .load_en(load), .load_val('0),
    .shift_en(step), .ser_in(acc[0]), .q(low)
  );

  assign product = {acc, low};

  // R6: outside load and run cycles the result does not move
  p_hold_product_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(product));
  // R2: operands are captured only through the handshake
  p_mcand_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mcand_q));
endmodule

// File: tb/seq_mult_test.sv
module seq_mult_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  wire         in_ready, done;
  wire  [31:0] product;

  seq_mult #(.W(16)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .done(done), .product(product)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  longint cyc = 0;
  always @(posedge clk) cyc++;

  logic [31:0] exp_q[$];
  longint      when_q[$];
  logic [31:0] last_exp = '0;
  logic        prev_done = 1'b0;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) begin
        check(in_ready == 1'b1, "R9 ready after done", 32'(in_ready), 32'd1);
        check(done == 1'b0, "R3 done one cycle", 32'(done), 32'd0);
      end
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 spurious done", 32'd1, 32'd0);
        end else begin
          logic [31:0] e;
          longint t;
          e = exp_q.pop_front();
          t = when_q.pop_front();
          check(product == e, "R4 product", product, e);
          check(cyc - t == 17, "R3 latency", 32'(cyc - t), 32'd17);
          last_exp = e;
        end
      end
      prev_done = done;
    end else begin
      prev_done = 1'b0;
    end
  end

  task automatic send(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(32'(a) * 32'(b));
    when_q.push_back(cyc);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(in_ready && exp_q.size() == 0)) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R3 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rs;
    rs = 32'h1F2E3D4C;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", 32'(done), 32'd0);
    check(in_ready == 1'b1, "R1 ready in reset", 32'(in_ready), 32'd1);
    check(product == 32'd0, "R1 product in reset", product, 32'd0);
    rst_n = 1'b1;

    // R4 / R7: directed operands
    send(16'd3, 16'd5);         wait_idle();
    send(16'd0, 16'hFFFF);      wait_idle();  // R7 zero multiplicand
    send(16'hFFFF, 16'd0);      wait_idle();  // R7 all multiplier bits 0
    send(16'hFFFF, 16'hFFFF);   wait_idle();  // R7 max carry
    check(last_exp == 32'hFFFE0001, "R7 max square", last_exp, 32'hFFFE0001);
    send(16'h8000, 16'd2);      wait_idle();
    send(16'd1, 16'hABCD);      wait_idle();

    // R6: result stays while idle
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(product == last_exp, "R6 hold", product, last_exp);
    end

    // R5: offers during a run are ignored
    send(16'h1234, 16'h5678);
    in_valid = 1'b1; op_a = 16'hDEAD; op_b = 16'hBEEF;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R5 ready low while busy", 32'(in_ready), 32'd0);
      op_a = op_a + 16'd1;
    end
    in_valid = 1'b0;
    wait_idle();
    check(last_exp == 32'h1234 * 32'h5678, "R5 result unaffected",
          last_exp, 32'h1234 * 32'h5678);

    // R8: asynchronous reset mid-run
    send(16'hBEEF, 16'h0101);
    repeat (4) @(negedge clk);
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #1;
    check(done == 1'b0, "R8 done after abort", 32'(done), 32'd0);
    check(in_ready == 1'b1, "R8 ready after abort", 32'(in_ready), 32'd1);
    check(product == 32'd0, "R8 product cleared", product, 32'd0);
    exp_q.delete(); when_q.delete();
    @(negedge clk) rst_n = 1'b1;
    send(16'd100, 16'd200);     wait_idle();

    // R9 / R2: back-to-back with in_valid held high
    @(negedge clk);
    in_valid = 1'b1; op_a = 16'd7; op_b = 16'd9;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(32'd63); when_q.push_back(cyc);
    @(negedge clk);
    check(in_ready == 1'b0, "R2 ready drops after transfer", 32'(in_ready), 32'd0);
    op_a = 16'd11; op_b = 16'd13;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(32'd143); when_q.push_back(cyc);
    @(negedge clk);
    in_valid = 1'b0;
    wait_idle();

    // R4: pseudo-random operands
    for (int i = 0; i < 20; i++) begin
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
      send(rs[15:0], rs[31:16]);
    end
    wait_idle();
    repeat (3) @(negedge clk);

    summary();
    $finish;
  end
endmodule